// File: doc/BRIEF.md
# SPI Register Control Port

This block is a serial slave that gives a host controller read and write access to a small configuration register file. The host starts a transaction by pulling an active-low latch line low. It then shifts in a command byte, a 16-bit register address and one or more data bytes on a serial clock. While the latch line is held low, the address advances on its own after every complete register word. A burst can therefore sweep across several registers, and across unmapped gaps between them, in one frame.

Most registers are one byte wide. The one at 0x4002 is a six-byte clock-multiplier register, so the port works out the word length from the address it is pointing at. A write to that register only takes effect when its final byte arrives, so the multiplier setting never holds a mix of old and new bytes. The register file has a clock-control byte at 0x4000 and a bank of general one-byte registers starting at 0x4008. The general registers stay locked until the clock-control core-enable bit is set and the multiplier reports lock.

All serial pins are oversampled by the system clock. The register contents are brought out as plain outputs so the rest of the chip can use them.

Top module: `spi_ctl_port`

## Requirements
- R1: The command byte is the first byte of a frame. Its bit 0 (the last bit shifted) selects the direction: 1 means read, 0 means write. The seven upper bits are sent as zero.
- R2: The two bytes after the command form the 16-bit start address, high byte first. Every byte is sent MSB first, and input bits are taken on rising edges of the serial clock.
- R3: During a read, the output bit changes only while the serial clock is low, just after a falling edge. It holds steady through the clock's high phase so the host can sample it on the rising edge.
- R4: The output enable is high only during the data phase of a read frame. It is low whenever the latch line is high, and low during write frames.
- R5: After each complete word, the address goes up by 1, whether or not a register exists at the old or the new address. For address 0x4002 a word is 6 bytes; for every other address it is 1 byte.
- R6: A write to an unmapped address changes nothing, and a read from one returns 0x00.
- R7: The register at 0x4002 is read and written as six bytes in this order: M[15:8], M[7:0], N[15:8], N[7:0], a configuration byte (bits 6:0 stored, bit 7 reads 0), and a control byte.
- R8: A write to 0x4002 updates M, N, the configuration byte and the enable bit together, when the sixth byte is received. If the frame ends before the sixth byte, all of them keep their old values.
- R9: In the control byte of 0x4002, bit 0 is a writable enable and bit 1 is read-only: it shows the pllLocked input. Bits 7:2 read 0.
- R10: The register at 0x4000 stores bits 3:0: bit 3 is the clock source, bits 2:1 are the input-frequency ratio, and bit 0 is core enable. Bits 7:4 read 0.
- R11: There are GEN_COUNT general registers at 0x4008 upward. They accept writes and return their contents only while core enable and pllLocked are both 1. Otherwise writes to them are dropped and reads return 0x00.
- R12: If the latch line rises in the middle of a byte, the partial byte is discarded and the next frame starts again with a command byte.
- R13: After reset, all registers are zero and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| spiClk | input | 1 | Serial clock from the host |
| spiLatchN | input | 1 | Active-low frame latch |
| spiMosi | input | 1 | Serial data from the host |
| spiMisoData | output | 1 | Serial read data |
| spiMisoEn | output | 1 | Drive enable for the read data pin (low means high impedance) |
| pllLocked | input | 1 | Lock indication from the clock multiplier |
| clkCtrl | output | 4 | Clock-control register bits 3:0 |
| pllM | output | 16 | Multiplier denominator |
| pllN | output | 16 | Multiplier numerator |
| pllCfg | output | 7 | Multiplier configuration bits 6:0 |
| pllEn | output | 1 | Multiplier enable |
| genRegs | output | 8*GEN_COUNT | General registers, register g in bits 8g+7:8g |

## Verification
Some properties are checked on every cycle: the output enable stays low while the latch is high, the read bit never changes while the serial clock is high, the multiplier fields change only inside an open frame, and the general registers change only while the access gate was open on the cycle before. Other behaviour can only be shown by running scenarios. These include address stepping across holes and across the six-byte word, the all-or-nothing commit of the multiplier register, the read-only lock bit, the dropping of a byte cut short by the latch, and the exact bytes returned by each read. The bench compares all of these against its own register model.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam logic [ADDR_W-1:0] CLK_ADDR = 16'h4000;
  localparam logic [ADDR_W-1:0] PLL_ADDR = 16'h4002;
  localparam logic [ADDR_W-1:0] GEN_BASE = 16'h4008;
  localparam int unsigned PLL_BYTES = 6;
  localparam int unsigned IDX_W = $clog2(PLL_BYTES);

  typedef enum logic [1:0] {PH_CMD, PH_ADRH, PH_ADRL, PH_DATA} phase_t;

  // strobe bundle from the serial sequencer to the register bank
  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] addr;
    logic [IDX_W-1:0]  idx;
    logic [7:0]        data;
  } wr_strobe_t;

  // index of the final byte of the word at address a
  function automatic logic [IDX_W-1:0] lastIdx(input logic [ADDR_W-1:0] a);
    return (a == PLL_ADDR) ? IDX_W'(PLL_BYTES - 1) : '0;
  endfunction
endpackage

// File: rtl/spi_ctl_seq.sv
module spi_ctl_seq
  import spi_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiClk,
  input  logic              spiLatchN,
  input  logic              spiMosi,
  input  logic [7:0]        rdByte,
  output wr_strobe_t        wrStb,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [IDX_W-1:0]  rdIdx,
  output logic              misoData,
  output logic              misoEn
);
  logic [2:0] sclkSync;
  logic [1:0] latSync, mosiSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      latSync  <= 2'b11;
      mosiSync <= '0;
    end else begin
      sclkSync <= {sclkSync[1:0], spiClk};
      latSync  <= {latSync[0], spiLatchN};
      mosiSync <= {mosiSync[0], spiMosi};
    end
  end

  logic sclkRise, sclkFall, frameOn;
  assign sclkRise = sclkSync[1] & ~sclkSync[2];
  assign sclkFall = ~sclkSync[1] & sclkSync[2];
  assign frameOn  = ~latSync[1];

  phase_t            phase;
  logic [2:0]        bitCnt;
  logic [7:0]        rxSh, txSh, rxNext;
  logic              isRead;
  logic [ADDR_W-1:0] addr;
  logic [IDX_W-1:0]  idx;

  assign rxNext = {rxSh[6:0], mosiSync[1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_CMD;
      bitCnt <= '0;
      rxSh   <= '0;
      txSh   <= '0;
      isRead <= 1'b0;
      addr   <= '0;
      idx    <= '0;
      wrStb  <= '0;
    end else begin
      wrStb.wrEn <= 1'b0;
      if (!frameOn) begin
        phase  <= PH_CMD;
        bitCnt <= '0;
        rxSh   <= '0;
        txSh   <= '0;
        isRead <= 1'b0;
        idx    <= '0;
      end else if (sclkRise) begin
        rxSh   <= rxNext;
        bitCnt <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) begin
          unique case (phase)
            PH_CMD:  begin isRead <= rxNext[0]; phase <= PH_ADRH; end
            PH_ADRH: begin addr[15:8] <= rxNext; phase <= PH_ADRL; end
            PH_ADRL: begin addr[7:0] <= rxNext; idx <= '0; phase <= PH_DATA; end
            default: begin
              if (!isRead) begin
                wrStb.wrEn <= 1'b1;
                wrStb.addr <= addr;
                wrStb.idx  <= idx;
                wrStb.data <= rxNext;
              end
              if (idx == lastIdx(addr)) begin
                idx  <= '0;
                addr <= addr + 1'b1;
              end else begin
                idx <= idx + 1'b1;
              end
            end
          endcase
        end
      end else if (sclkFall && phase == PH_DATA && isRead) begin
        txSh <= (bitCnt == 3'd0) ? rdByte : {txSh[6:0], 1'b0};
      end
    end
  end

  assign rdAddr   = addr;
  assign rdIdx    = idx;
  assign misoData = txSh[7];
  assign misoEn   = ~spiLatchN & isRead & (phase == PH_DATA);
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_ctl_pkg::*;
#(
  parameter int unsigned GEN_COUNT = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  wr_strobe_t             wrStb,
  input  logic                   pllLocked,
  input  logic [ADDR_W-1:0]      rdAddr,
  input  logic [IDX_W-1:0]       rdIdx,
  output logic [7:0]             rdByte,
  output logic [3:0]             clkCtrl,
  output logic [15:0]            pllM,
  output logic [15:0]            pllN,
  output logic [6:0]             pllCfg,
  output logic                   pllEn,
  output logic [8*GEN_COUNT-1:0] genRegs
);
  localparam int unsigned STAGE_N = 4;

  logic [7:0] stage [STAGE_N];
  logic [6:0] cfgStage;
  logic       gateOpen;

  assign gateOpen = clkCtrl[0] & pllLocked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkCtrl  <= '0;
      pllM     <= '0;
      pllN     <= '0;
      pllCfg   <= '0;
      pllEn    <= 1'b0;
      cfgStage <= '0;
      for (int i = 0; i < STAGE_N; i++) stage[i] <= '0;
    end else if (wrStb.wrEn) begin
      if (wrStb.addr == CLK_ADDR) clkCtrl <= wrStb.data[3:0];
      if (wrStb.addr == PLL_ADDR) begin
        if (wrStb.idx < IDX_W'(STAGE_N)) stage[wrStb.idx[1:0]] <= wrStb.data;
        else if (wrStb.idx == IDX_W'(STAGE_N)) cfgStage <= wrStb.data[6:0];
        else begin
          pllM   <= {stage[0], stage[1]};
          pllN   <= {stage[2], stage[3]};
          pllCfg <= cfgStage;
          pllEn  <= wrStb.data[0];
        end
      end
    end
  end

  for (genvar g = 0; g < GEN_COUNT; g++) begin : g_gen
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) genRegs[8*g +: 8] <= '0;
      else if (wrStb.wrEn && gateOpen && wrStb.addr == GEN_BASE + ADDR_W'(g))
        genRegs[8*g +: 8] <= wrStb.data;
    end
  end

  always_comb begin
    rdByte = '0;
    if (rdAddr == CLK_ADDR) rdByte = {4'b0, clkCtrl};
    else if (rdAddr == PLL_ADDR) begin
      unique case (rdIdx)
        3'd0:    rdByte = pllM[15:8];
        3'd1:    rdByte = pllM[7:0];
        3'd2:    rdByte = pllN[15:8];
        3'd3:    rdByte = pllN[7:0];
        3'd4:    rdByte = {1'b0, pllCfg};
        default: rdByte = {6'b0, pllLocked, pllEn};
      endcase
    end else begin
      for (int g = 0; g < GEN_COUNT; g++)
        if (gateOpen && rdAddr == GEN_BASE + ADDR_W'(g)) rdByte = genRegs[8*g +: 8];
    end
  end
endmodule

// File: rtl/spi_ctl_port.sv
module spi_ctl_port
  import spi_ctl_pkg::*;
#(
  parameter int unsigned GEN_COUNT = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   spiClk,
  input  logic                   spiLatchN,
  input  logic                   spiMosi,
  output logic                   spiMisoData,
  output logic                   spiMisoEn,
  input  logic                   pllLocked,
  output logic [3:0]             clkCtrl,
  output logic [15:0]            pllM,
  output logic [15:0]            pllN,
  output logic [6:0]             pllCfg,
  output logic                   pllEn,
  output logic [8*GEN_COUNT-1:0] genRegs
);
  wr_strobe_t        wrStb;
  logic [ADDR_W-1:0] rdAddr;
  logic [IDX_W-1:0]  rdIdx;
  logic [7:0]        rdByte;

  spi_ctl_seq seq_i (
    .clk(clk), .rstN(rstN), .spiClk(spiClk), .spiLatchN(spiLatchN), .spiMosi(spiMosi),
    .rdByte(rdByte), .wrStb(wrStb), .rdAddr(rdAddr), .rdIdx(rdIdx),
    .misoData(spiMisoData), .misoEn(spiMisoEn)
  );

  spi_reg_bank #(.GEN_COUNT(GEN_COUNT)) bank_i (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .pllLocked(pllLocked),
    .rdAddr(rdAddr), .rdIdx(rdIdx), .rdByte(rdByte),
    .clkCtrl(clkCtrl), .pllM(pllM), .pllN(pllN), .pllCfg(pllCfg), .pllEn(pllEn),
    .genRegs(genRegs)
  );
endmodule

// File: rtl/spi_ctl_port_chk.sv
module spi_ctl_port_chk #(
  parameter int unsigned GEN_COUNT = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   spiClk,
  input logic                   spiLatchN,
  input logic                   spiMisoData,
  input logic                   spiMisoEn,
  input logic                   pllLocked,
  input logic                   coreEn,
  input logic [15:0]            pllM,
  input logic [8*GEN_COUNT-1:0] genRegs
);
  // R4: pin released whenever the frame latch is high
  a_r4_release_idle: assert property (@(posedge clk) disable iff (!rstN)
    spiLatchN |-> !spiMisoEn);

  // R3: read bit moves only in the low phase of the serial clock
  a_r3_shift_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (spiMisoEn && $past(spiMisoEn) && spiMisoData != $past(spiMisoData)) |-> !spiClk);

  // R8: multiplier fields update only inside an open frame
  a_r8_commit_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    (pllM != $past(pllM)) |-> !spiLatchN);

  // R11: general registers change only when the gate was open
  a_r11_gated_write: assert property (@(posedge clk) disable iff (!rstN)
    (genRegs != $past(genRegs)) |-> $past(coreEn && pllLocked));
endmodule

bind spi_ctl_port spi_ctl_port_chk #(.GEN_COUNT(GEN_COUNT)) chk_i (
  .clk(clk), .rstN(rstN), .spiClk(spiClk), .spiLatchN(spiLatchN),
  .spiMisoData(spiMisoData), .spiMisoEn(spiMisoEn), .pllLocked(pllLocked),
  .coreEn(clkCtrl[0]), .pllM(pllM), .genRegs(genRegs)
);

// File: tb/spi_ctl_port_tb_top.sv
`timescale 1ns/1ps
module spi_ctl_port_tb_top;
  localparam int GEN_COUNT = 4;
  localparam int HALF = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic spiClk = 1'b0, spiLatchN = 1'b1, spiMosi = 1'b0, pllLocked = 1'b0;
  logic spiMisoData, spiMisoEn, pllEn;
  logic [3:0] clkCtrl;
  logic [15:0] pllM, pllN;
  logic [6:0] pllCfg;
  logic [8*GEN_COUNT-1:0] genRegs;

  always #2.5 clk = ~clk;

  spi_ctl_port #(.GEN_COUNT(GEN_COUNT)) dut_i (
    .clk(clk), .rstN(rstN), .spiClk(spiClk), .spiLatchN(spiLatchN), .spiMosi(spiMosi),
    .spiMisoData(spiMisoData), .spiMisoEn(spiMisoEn), .pllLocked(pllLocked),
    .clkCtrl(clkCtrl), .pllM(pllM), .pllN(pllN), .pllCfg(pllCfg), .pllEn(pllEn),
    .genRegs(genRegs)
  );

  int checks = 0, errors = 0, enBad = 0, holdBad = 0;

  // reference model
  logic [3:0] mClk; logic [15:0] mM, mN; logic [6:0] mCfg; logic mEn;
  logic [7:0] mGen [GEN_COUNT];
  logic [7:0] mStage [5];
  logic [7:0] txBuf [32];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int lastIdxM(input logic [15:0] a);
    return (a == 16'h4002) ? 5 : 0;
  endfunction

  function automatic logic gateM();
    return mClk[0] & pllLocked;
  endfunction

  task automatic mWrite(input logic [15:0] a, input int ix, input logic [7:0] d);
    if (a == 16'h4000) mClk = d[3:0];
    else if (a == 16'h4002) begin
      if (ix < 5) mStage[ix] = d;
      else begin
        mM = {mStage[0], mStage[1]}; mN = {mStage[2], mStage[3]};
        mCfg = mStage[4][6:0]; mEn = d[0];
      end
    end else if (a >= 16'h4008 && a < 16'h4008 + GEN_COUNT && gateM())
      mGen[a - 16'h4008] = d;
  endtask

  function automatic logic [7:0] mRead(input logic [15:0] a, input int ix);
    if (a == 16'h4000) return {4'b0, mClk};
    if (a == 16'h4002) begin
      case (ix)
        0: return mM[15:8];
        1: return mM[7:0];
        2: return mN[15:8];
        3: return mN[7:0];
        4: return {1'b0, mCfg};
        default: return {6'b0, pllLocked, mEn};
      endcase
    end
    if (a >= 16'h4008 && a < 16'h4008 + GEN_COUNT && gateM()) return mGen[a - 16'h4008];
    return 8'h00;
  endfunction

  function automatic logic [8*GEN_COUNT-1:0] mGenPacked();
    logic [8*GEN_COUNT-1:0] v;
    for (int g = 0; g < GEN_COUNT; g++) v[8*g +: 8] = mGen[g];
    return v;
  endfunction

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input logic expEn);
    for (int i = 7; i >= 0; i--) begin
      spiMosi = tx[i];
      waitClk(HALF);
      rx[i] = spiMisoData;
      if (spiMisoEn !== expEn) enBad++;
      spiClk = 1'b1;
      waitClk(HALF);
      if (expEn && spiMisoData !== rx[i]) holdBad++;
      spiClk = 1'b0;
    end
  endtask

  // one frame; read bytes are compared to the model
  task automatic frame(input logic rd, input logic [15:0] addr, input int n, input string tag);
    logic [7:0] rx;
    logic [15:0] a;
    int ix;
    a = addr; ix = 0;
    spiLatchN = 1'b0;
    waitClk(HALF);
    xfer({7'b0, rd}, rx, 1'b0);
    xfer(addr[15:8], rx, 1'b0);
    xfer(addr[7:0], rx, 1'b0);
    for (int k = 0; k < n; k++) begin
      if (rd) begin
        xfer(8'h00, rx, 1'b1);
        chk($sformatf("%s read @%h.%0d", tag, a, ix), rx, mRead(a, ix));
      end else begin
        xfer(txBuf[k], rx, 1'b0);
        mWrite(a, ix, txBuf[k]);
      end
      if (ix == lastIdxM(a)) begin ix = 0; a = a + 1; end else ix++;
    end
    waitClk(HALF);
    spiLatchN = 1'b1;
    waitClk(2 * HALF);
  endtask

  task automatic cmpOut(input string tag);
    chk({tag, " clkCtrl"}, clkCtrl, mClk);
    chk({tag, " pllM"}, pllM, mM);
    chk({tag, " pllN"}, pllN, mN);
    chk({tag, " pllCfg"}, pllCfg, mCfg);
    chk({tag, " pllEn"}, pllEn, mEn);
    chk({tag, " genRegs"}, genRegs, mGenPacked());
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, run hung (all requirements)");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    void'($urandom(32'hA5C3));
    mClk = '0; mM = '0; mN = '0; mCfg = '0; mEn = 1'b0;
    for (int g = 0; g < GEN_COUNT; g++) mGen[g] = '0;
    for (int i = 0; i < 5; i++) mStage[i] = '0;
    waitClk(10);
    // R13: reset state
    chk("R13 reset outputs", {clkCtrl, pllM, pllN, pllCfg, pllEn, genRegs}, '0);
    chk("R13 R4 miso enable after reset", spiMisoEn, 1'b0);
    rstN = 1'b1;
    waitClk(5);

    // R10 R1 R2: clock control write then read back
    txBuf[0] = 8'hFB;
    frame(1'b0, 16'h4000, 1, "R10");
    cmpOut("R10 R2 write");
    frame(1'b1, 16'h4000, 1, "R10 R1");

    // R11: gate closed (no lock) blocks general registers
    pllLocked = 1'b0;
    txBuf[0] = 8'h5A;
    frame(1'b0, 16'h4008, 1, "R11");
    cmpOut("R11 gate closed write");
    frame(1'b1, 16'h4008, 1, "R11 gate closed");
    pllLocked = 1'b1;
    frame(1'b0, 16'h4008, 1, "R11");
    cmpOut("R11 gate open write");
    frame(1'b1, 16'h4008, 1, "R11 gate open");

    // R7 R9: six-byte multiplier register
    txBuf[0] = 8'h00; txBuf[1] = 8'h7D; txBuf[2] = 8'h00; txBuf[3] = 8'h0C;
    txBuf[4] = 8'hA3; txBuf[5] = 8'hFF;
    frame(1'b0, 16'h4002, 6, "R7");
    cmpOut("R7 multiplier write");
    chk("R7 pllCfg bit7 dropped", pllCfg, 7'h23);
    frame(1'b1, 16'h4002, 6, "R7 R9 locked");
    pllLocked = 1'b0;
    frame(1'b1, 16'h4002, 6, "R9 unlocked");
    pllLocked = 1'b1;

    // R8: frame cut after three bytes leaves everything unchanged
    txBuf[0] = 8'h11; txBuf[1] = 8'h22; txBuf[2] = 8'h33;
    frame(1'b0, 16'h4002, 3, "R8");
    mStage[0] = 8'h00; mStage[1] = 8'h7D; mStage[2] = 8'h00;
    cmpOut("R8 partial write");
    chk("R8 pllM kept", pllM, 16'h007D);

    // R5 R6: burst across holes and the six-byte word
    for (int k = 0; k < 15; k++) txBuf[k] = 8'(8'h30 + k);
    frame(1'b0, 16'h4000, 15, "R5");
    cmpOut("R5 R6 burst write");
    frame(1'b1, 16'h3FFF, 17, "R5 R6 burst");

    // R12: latch raised mid-byte
    spiLatchN = 1'b0;
    waitClk(HALF);
    xfer(8'h00, rx, 1'b0);
    xfer(8'h40, rx, 1'b0);
    xfer(8'h00, rx, 1'b0);
    for (int i = 0; i < 4; i++) begin
      spiMosi = 1'b1; waitClk(HALF); spiClk = 1'b1; waitClk(HALF); spiClk = 1'b0;
    end
    waitClk(HALF);
    spiLatchN = 1'b1;
    waitClk(2 * HALF);
    cmpOut("R12 partial byte discarded");
    txBuf[0] = 8'h05;
    frame(1'b0, 16'h4000, 1, "R12");
    chk("R12 next frame clean", clkCtrl, 4'h5);

    // random frames over the whole map
    for (int t = 0; t < 30; t++) begin
      logic [15:0] a;
      int n;
      logic rd;
      a  = 16'h3FFE + 16'($urandom_range(0, 16));
      n  = $urandom_range(1, 9);
      rd = 1'($urandom_range(0, 1));
      for (int k = 0; k < n; k++) txBuf[k] = 8'($urandom);
      if ($urandom_range(0, 3) == 0) pllLocked = ~pllLocked;
      frame(rd, a, n, "R5 R6 R11 random");
      cmpOut("R5 R6 R8 R11 random");
    end

    chk("R4 enable pattern over all frames", enBad, 0);
    chk("R3 read bit held through clock high", holdBad, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule